// File: doc/BRIEF.md
# Bus Cycle Break Condition Matcher

This block observes every completed bus cycle and raises a break interrupt request when that cycle fits a condition that software has programmed. The condition is held in a 6-bit control register built from three 2-bit selectors. The first selector picks the cycle kind (instruction fetch, data access, or either). The second picks the direction (read, write, or either). The third picks the operand size, or leaves size out of the condition.

Each bus cycle arrives with a valid strobe and three attributes: a fetch/data flag, a read/write flag and a size code. A cycle that meets every enabled criterion sets a sticky flag on the following clock edge. The interrupt request stays high for as long as the flag is set. Software removes the flag with a one-cycle clear pulse. Instruction fetches are always judged as word-size accesses, whatever size code the fetch carries. Data accesses are judged on the size the initiator asked for.

A control value that breaks on fetches but selects byte or longword size can never produce a match. The block reports such a value on a status output.

Top module: `bcb_matcher`

## Requirements
- R1: After reset, the control register reads 6'b000000 and both `brk_flag` and `brk_irq` are 0.
- R2: The control field is laid out as follows. Bits [5:4] are the kind selector, bits [3:2] are the direction selector and bits [1:0] are the size selector. If the kind selector or the direction selector is 00, no cycle ever sets the flag.
- R3: The kind selector takes the values 01 = instruction fetches only, 10 = data accesses only and 11 = both. The `cyc_is_data` input is 0 for a fetch and 1 for a data access.
- R4: The direction selector takes the values 01 = reads only, 10 = writes only and 11 = both. The `cyc_is_write` input is 0 for a read and 1 for a write.
- R5: The size selector takes the values 00 = size is not part of the condition, 01 = byte, 10 = word and 11 = longword. `cyc_size` uses the same codes, and the size code 00 matches no nonzero selector.
- R6: A fetch is compared as a word access (10), whatever `cyc_size` it carries.
- R7: When `cyc_valid` is low, the cycle never sets the flag.
- R8: A matching cycle sets `brk_flag` at the next rising clock edge. The flag then stays set until it is cleared, and `brk_irq` equals `brk_flag`.
- R9: When `brk_clr` is high, `brk_flag` is 0 after the next edge, even if a matching cycle arrives in that same cycle.
- R10: `cfg_unmatchable` is 1 exactly when the stored kind selector is 01 and the stored size selector is 01 or 11.
- R11: A write through `ctl_we` updates the control register at the next edge. A bus cycle presented in the same cycle as the write is judged against the old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 6 | Control value to be written |
| ctl_q | output | 6 | Stored control value |
| cyc_valid | input | 1 | A bus cycle completes in this clock cycle |
| cyc_is_data | input | 1 | 0 = instruction fetch, 1 = data access |
| cyc_is_write | input | 1 | 0 = read, 1 = write |
| cyc_size | input | 2 | Requested operand size (01 byte, 10 word, 11 longword) |
| brk_clr | input | 1 | One-cycle clear of the break flag |
| brk_flag | output | 1 | Sticky break match flag |
| brk_irq | output | 1 | Break interrupt request |
| cfg_unmatchable | output | 1 | Stored control can never match |

## Verification
Two events can land in the same clock cycle. One pair is a matching cycle together with a clear pulse; the bench drives both on one edge and expects the flag to be low afterwards. The other pair is a control write together with a bus cycle; the bench drives both on one edge and expects the cycle to be judged on the old control value. A behavioural reference model holds the expected flag and control value and is compared against the outputs on every clock, through directed cases and a long random run in which clear, write and cycle collide freely.

// File: rtl/bcb_pkg.sv
package bcb_pkg;
  localparam int SEL_W = 2;
  localparam int CTL_W = 3 * SEL_W;

  typedef logic [SEL_W-1:0] sel_t;

  typedef struct packed {
    sel_t kind;
    sel_t dir;
    sel_t size;
  } ctl_t;

  localparam sel_t SEL_OFF  = 2'b00;
  localparam sel_t SZ_BYTE  = 2'b01;
  localparam sel_t SZ_WORD  = 2'b10;
  localparam sel_t SZ_LONG  = 2'b11;
  localparam sel_t KIND_FET = 2'b01;

  // kind selector: bit0 enables fetches, bit1 enables data accesses
  function automatic logic kind_hit(input sel_t sel, input logic is_data);
    return is_data ? sel[1] : sel[0];
  endfunction

  // direction selector: bit0 enables reads, bit1 enables writes
  function automatic logic dir_hit(input sel_t sel, input logic is_write);
    return is_write ? sel[1] : sel[0];
  endfunction

  // size actually compared: fetches are always judged as word accesses
  function automatic sel_t judged_size(input logic is_data, input sel_t req);
    return is_data ? req : SZ_WORD;
  endfunction

  function automatic logic size_hit(input sel_t sel, input sel_t sz);
    return (sel == SEL_OFF) || (sel == sz);
  endfunction

  function automatic logic never_hits(input ctl_t c);
    return (c.kind == KIND_FET) && (c.size == SZ_BYTE || c.size == SZ_LONG);
  endfunction
endpackage

// File: rtl/bcb_ctl_reg.sv
module bcb_ctl_reg
  import bcb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CTL_W-1:0] wdata,
  output ctl_t             ctl,
  output logic             chan_off,
  output logic             unmatchable
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl <= '0;
    else if (we) ctl <= ctl_t'(wdata);
  end

  assign chan_off    = (ctl.kind == SEL_OFF) || (ctl.dir == SEL_OFF);
  assign unmatchable = never_hits(ctl);
endmodule

// File: rtl/bcb_cycle_cmp.sv
module bcb_cycle_cmp
  import bcb_pkg::*;
(
  input  ctl_t       ctl,
  input  logic       chan_off,
  input  logic       valid,
  input  logic       is_data,
  input  logic       is_write,
  input  sel_t       size,
  output logic       kind_ok,
  output logic       dir_ok,
  output logic       size_ok,
  output logic       match
);
  sel_t eff_size;

  always_comb begin
    eff_size = judged_size(is_data, size);
    kind_ok  = kind_hit(ctl.kind, is_data);
    dir_ok   = dir_hit(ctl.dir, is_write);
    size_ok  = size_hit(ctl.size, eff_size);
    match    = valid && !chan_off && kind_ok && dir_ok && size_ok;
  end
endmodule

// File: rtl/bcb_sticky.sv
module bcb_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= 1'b0;
    else if (clr) q <= 1'b0;
    else if (set) q <= 1'b1;
  end
endmodule

// File: rtl/bcb_matcher.sv
module bcb_matcher
  import bcb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  output logic [CTL_W-1:0] ctl_q,
  input  logic             cyc_valid,
  input  logic             cyc_is_data,
  input  logic             cyc_is_write,
  input  logic [SEL_W-1:0] cyc_size,
  input  logic             brk_clr,
  output logic             brk_flag,
  output logic             brk_irq,
  output logic             cfg_unmatchable
);
  ctl_t ctl;
  logic chan_off;
  logic kind_ok, dir_ok, size_ok;
  logic cyc_match;

  bcb_ctl_reg u_ctl (
    .clk(clk), .rst_n(rst_n), .we(ctl_we), .wdata(ctl_wdata),
    .ctl(ctl), .chan_off(chan_off), .unmatchable(cfg_unmatchable)
  );

  bcb_cycle_cmp u_cmp (
    .ctl(ctl), .chan_off(chan_off), .valid(cyc_valid),
    .is_data(cyc_is_data), .is_write(cyc_is_write), .size(cyc_size),
    .kind_ok(kind_ok), .dir_ok(dir_ok), .size_ok(size_ok), .match(cyc_match)
  );

  bcb_sticky u_flag (
    .clk(clk), .rst_n(rst_n), .set(cyc_match), .clr(brk_clr), .q(brk_flag)
  );

  assign ctl_q   = ctl;
  assign brk_irq = brk_flag;
endmodule

// File: rtl/bcb_checker.sv
module bcb_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [5:0] ctl_q,
  input logic       cyc_valid,
  input logic       brk_clr,
  input logic       cyc_match,
  input logic       brk_flag,
  input logic       brk_irq,
  input logic       cfg_unmatchable
);
  p_off_no_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[5:4] == 2'b00 || ctl_q[3:2] == 2'b00) |-> !cyc_match);

  p_invalid_no_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_valid |-> !cyc_match);

  p_match_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_match && !brk_clr) |=> brk_flag);

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_flag && !brk_clr) |=> brk_flag);

  p_irq_tracks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    brk_irq == brk_flag);

  p_clear_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    brk_clr |=> !brk_flag);

  p_dead_cfg_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_unmatchable |-> !cyc_match);
endmodule

bind bcb_matcher bcb_checker u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_q(ctl_q), .cyc_valid(cyc_valid),
  .brk_clr(brk_clr), .cyc_match(cyc_match), .brk_flag(brk_flag),
  .brk_irq(brk_irq), .cfg_unmatchable(cfg_unmatchable)
);

// File: tb/bcb_matcher_tb.sv
`timescale 1ns/1ps
module bcb_matcher_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_we = 1'b0;
  logic [5:0] ctl_wdata = '0;
  logic [5:0] ctl_q;
  logic       cyc_valid = 1'b0, cyc_is_data = 1'b0, cyc_is_write = 1'b0;
  logic [1:0] cyc_size = '0;
  logic       brk_clr = 1'b0;
  logic       brk_flag, brk_irq, cfg_unmatchable;

  int n_vec = 0;
  int n_bad = 0;
  logic [5:0] m_ctl = '0;
  bit         m_flag = 1'b0;

  always #5 clk = ~clk;

  bcb_matcher dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_q(ctl_q), .cyc_valid(cyc_valid), .cyc_is_data(cyc_is_data),
    .cyc_is_write(cyc_is_write), .cyc_size(cyc_size), .brk_clr(brk_clr),
    .brk_flag(brk_flag), .brk_irq(brk_irq), .cfg_unmatchable(cfg_unmatchable)
  );

  // reference: a cycle hits when every enabled criterion is listed as allowed
  function automatic bit ref_hit(input logic [5:0] c, input bit v, input bit d,
                                 input bit w, input logic [1:0] sz);
    int want_sz;
    bit ok;
    if (!v) return 0;
    if (c[5:4] == 0 || c[3:2] == 0) return 0;
    ok = 1;
    case (c[5:4])
      2'b01: if (d)  ok = 0;
      2'b10: if (!d) ok = 0;
      default: ;
    endcase
    case (c[3:2])
      2'b01: if (w)  ok = 0;
      2'b10: if (!w) ok = 0;
      default: ;
    endcase
    want_sz = d ? int'(sz) : 2;
    if (c[1:0] != 0 && int'(c[1:0]) != want_sz) ok = 0;
    return ok;
  endfunction

  task automatic compare(input string req);
    bit exp_dead;
    exp_dead = (m_ctl[5:4] == 2'b01) && (m_ctl[1:0] == 2'b01 || m_ctl[1:0] == 2'b11);
    n_vec++;
    if (brk_flag !== m_flag || brk_irq !== m_flag || ctl_q !== m_ctl ||
        cfg_unmatchable !== exp_dead) begin
      n_bad++;
      $display("FAIL %s: flag=%b irq=%b ctl=%b dead=%b expected flag=%b irq=%b ctl=%b dead=%b",
               req, brk_flag, brk_irq, ctl_q, cfg_unmatchable,
               m_flag, m_flag, m_ctl, exp_dead);
    end
  endtask

  task automatic step(input string req, input bit we, input logic [5:0] wd,
                      input bit v, input bit d, input bit w,
                      input logic [1:0] sz, input bit clr);
    bit hit;
    ctl_we = we; ctl_wdata = wd; cyc_valid = v; cyc_is_data = d;
    cyc_is_write = w; cyc_size = sz; brk_clr = clr;
    hit = ref_hit(m_ctl, v, d, w, sz);
    @(posedge clk);
    #1;
    if (clr) m_flag = 0;
    else if (hit) m_flag = 1;
    if (we) m_ctl = wd;
    @(negedge clk);
    compare(req);
  endtask

  task automatic prog(input string req, input logic [5:0] c);
    step(req, 1, c, 0, 0, 0, 2'b00, 1);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");

    // R2: channel off, cycles of every kind
    step("R2", 0, 0, 1, 0, 0, 2'b10, 0);
    prog("R2", 6'b00_11_00);
    step("R2", 0, 0, 1, 1, 1, 2'b11, 0);
    prog("R2", 6'b11_00_00);
    step("R2", 0, 0, 1, 0, 0, 2'b10, 0);

    // R3: data only rejects fetch, accepts data
    prog("R3", 6'b10_11_00);
    step("R3", 0, 0, 1, 0, 0, 2'b10, 0);
    step("R3", 0, 0, 1, 1, 0, 2'b01, 0);
    step("R3", 0, 0, 0, 0, 0, 2'b00, 0);

    // R4: writes only
    prog("R4", 6'b11_10_00);
    step("R4", 0, 0, 1, 1, 0, 2'b11, 0);
    step("R4", 0, 0, 1, 1, 1, 2'b11, 0);

    // R5: longword data, size 00 never matches a set selector
    prog("R5", 6'b10_11_11);
    step("R5", 0, 0, 1, 1, 0, 2'b10, 0);
    step("R5", 0, 0, 1, 1, 0, 2'b00, 0);
    step("R5", 0, 0, 1, 1, 0, 2'b11, 0);

    // R6: fetch judged word even when carrying longword
    prog("R6", 6'b01_01_10);
    step("R6", 0, 0, 1, 0, 0, 2'b11, 0);
    prog("R6", 6'b01_01_11);
    step("R6", 0, 0, 1, 0, 0, 2'b11, 0);

    // R7: invalid cycle ignored
    prog("R7", 6'b11_11_00);
    step("R7", 0, 0, 0, 1, 1, 2'b01, 0);

    // R8/R9: sticky, then clear colliding with a match
    step("R8", 0, 0, 1, 1, 1, 2'b01, 0);
    step("R8", 0, 0, 0, 0, 0, 2'b00, 0);
    step("R9", 0, 0, 1, 1, 1, 2'b01, 1);

    // R10: unmatchable flag values
    prog("R10", 6'b01_11_01);
    prog("R10", 6'b01_11_10);
    prog("R10", 6'b11_11_11);

    // R11: write and cycle on the same edge use the old value
    prog("R11", 6'b00_00_00);
    step("R11", 1, 6'b11_11_00, 1, 1, 1, 2'b10, 0);
    step("R11", 0, 0, 1, 1, 1, 2'b10, 0);

    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      r = $urandom;
      step("R8", r[0] & r[1] & r[2], r[8:3], r[9] | r[10], r[11], r[12],
           r[14:13], r[15] & r[16] & r[17]);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule